// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss in hardware. Given a 32-bit virtual address, an access kind (read or write) and the requester's privilege (user or supervisor), it reads two 32-bit words from memory. The first is the directory entry, found through a physical base address. The second is the table entry, found through the frame that the directory entry names. It then reports either a finished translation or a fault. A finished translation carries the physical page number, the full physical address and the combined permission flags, ready to be written into a TLB. A fault carries a cause code. The instruction that missed stalls while `busy` is high, and no software takes part in the walk.

The walker handles one walk at a time. It issues single-word reads on a request/response port and waits as long as memory needs for each response. Entry flag bits sit at fixed positions. Bit 0 means present, bit 1 means writable and bit 2 means user-accessible. The page frame number is in bits 31:12. Rights are the AND of the directory and table levels, so a directory entry restricts every one of the 1024 pages below it.

Top module: `page_walker`

## Requirements
- R1: While reset is held and after it, the walker is idle: `busy`, `mem_rd_valid` and `done_valid` are 0 until a request is accepted.
- R2: A request is accepted when `req_valid` is high while `busy` is low. In the next cycle one read is issued to address `base_addr + 4*vaddr[31:22]`, using the base and address sampled at acceptance.
- R3: After a present directory entry returns, one read is issued to `{dir_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R4: A directory entry with bit 0 clear ends the walk with `done_fault`=1 and `done_cause`=1, and no table read is issued.
- R5: A table entry with bit 0 clear ends the walk with `done_fault`=1 and `done_cause`=2.
- R6: A write is permitted only if bit 1 is set in both entries. A user access is permitted only if bit 2 is set in both entries. Supervisor reads need only the present bits. A denied access ends with `done_fault`=1 and `done_cause`=3.
- R7: A successful walk gives `done_fault`=0, `done_cause`=0, `done_ppn` = table entry bits 31:12, and `done_paddr` = {`done_ppn`, vaddr[11:0]}. It also gives `done_writable` and `done_user` as the AND of bits 1 and 2 across both entries.
- R8: `busy` rises the cycle after acceptance and stays high through the result cycle. Requests presented while `busy` is high are ignored.
- R9: `done_valid` is a single-cycle pulse for each walk. A read request lasts one cycle, and only one read is outstanding at a time.
- R10: On a fault, `done_ppn`, `done_paddr`, `done_writable` and `done_user` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only while idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| base_addr | input | 32 | Physical address of the page directory |
| busy | output | 1 | Walk in progress |
| mem_rd_valid | output | 1 | Word read request, one cycle |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 directory absent, 2 table absent, 3 protection |
| done_ppn | output | 20 | Physical page number |
| done_paddr | output | 32 | Translated physical address |
| done_writable | output | 1 | Combined write right |
| done_user | output | 1 | Combined user right |

## Verification
The assertions check the handshake rules on every cycle. These rules are: idle silence, the busy rise after acceptance, single-cycle read and result pulses, the directory read address, the placement of the page offset, and zeroed payload with a nonzero cause on faults. Other behaviour needs memory contents that the bench chooses, so only the directed scenarios can show it. This covers the table-entry address, each fault cause at its own level, the AND of rights when either level withholds them, ignoring requests during a walk, and varied memory latency.

// File: rtl/pw_pkg.sv
// Package: shared state and fault-cause encodings for the page walker,
// plus the bit positions of the flags inside a directory or table entry.
package pw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_DIR,
        ST_WAIT_DIR,
        ST_FETCH_TBL,
        ST_WAIT_TBL,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'd0,
        CAUSE_DIR_ABSENT = 2'd1,
        CAUSE_TBL_ABSENT = 2'd2,
        CAUSE_PROT       = 2'd3
    } fault_cause_t;

    localparam int FLAG_PRESENT = 0;
    localparam int FLAG_WRITE   = 1;
    localparam int FLAG_USER    = 2;
endpackage

// File: rtl/pw_addr_gen.sv
// Module: pw_addr_gen
// Forms the byte address of the next entry to read. It computes the
// directory slot from the base and the upper index, or the table slot
// from the directory entry frame and the middle index.
// Assumes entries are ENTRY_W bits wide and frames are page aligned.
module pw_addr_gen #(
    parameter int VA_W    = 32,
    parameter int ENTRY_W = 32,
    parameter int IDX_W   = 10,
    parameter int OFF_W   = 12
) (
    input  logic [ENTRY_W-1:0] base,
    input  logic [VA_W-1:0]    vaddr,
    input  logic [ENTRY_W-1:0] dir_entry,
    input  logic               sel_table,
    output logic [ENTRY_W-1:0] addr
);
    localparam int SLOT_SH = $clog2(ENTRY_W / 8);

    logic [IDX_W-1:0]   dir_idx;
    logic [IDX_W-1:0]   tbl_idx;
    logic [ENTRY_W-1:0] frame_base;

    // Slice the indices and select the slot address for the current level.
    always_comb begin
        dir_idx    = vaddr[VA_W-1 -: IDX_W];
        tbl_idx    = vaddr[OFF_W +: IDX_W];
        frame_base = {dir_entry[ENTRY_W-1:OFF_W], {OFF_W{1'b0}}};
        if (sel_table)
            addr = frame_base + (ENTRY_W'(tbl_idx) << SLOT_SH);
        else
            addr = base + (ENTRY_W'(dir_idx) << SLOT_SH);
    end
endmodule

// File: rtl/pw_perm_check.sv
// Module: pw_perm_check
// Combines the rights of both levels by AND and decides whether the
// requested access is allowed. Assumes both entries are present.
module pw_perm_check #(
    parameter int ENTRY_W = 32
) (
    input  logic [ENTRY_W-1:0] dir_entry,
    input  logic [ENTRY_W-1:0] tbl_entry,
    input  logic               is_write,
    input  logic               is_user,
    output logic               eff_write,
    output logic               eff_user,
    output logic               deny
);
    import pw_pkg::*;

    // Merge rights across levels and test them against the access.
    always_comb begin
        eff_write = dir_entry[FLAG_WRITE] & tbl_entry[FLAG_WRITE];
        eff_user  = dir_entry[FLAG_USER]  & tbl_entry[FLAG_USER];
        deny      = (is_write & ~eff_write) | (is_user & ~eff_user);
    end
endmodule

// File: rtl/page_walker.sv
// Module: page_walker
// Two-level table walker. It accepts one request while idle, reads the
// directory entry, then the table entry, and reports a translation or a
// fault for one cycle. Assumes memory answers every read exactly once
// and takes requests without back-pressure.
module page_walker #(
    parameter int VA_W    = 32,
    parameter int ENTRY_W = 32,
    parameter int IDX_W   = 10,
    parameter int OFF_W   = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 req_write,
    input  logic                 req_user,
    input  logic [ENTRY_W-1:0]   base_addr,
    output logic                 busy,
    output logic                 mem_rd_valid,
    output logic [ENTRY_W-1:0]   mem_rd_addr,
    input  logic                 mem_rsp_valid,
    input  logic [ENTRY_W-1:0]   mem_rsp_data,
    output logic                 done_valid,
    output logic                 done_fault,
    output logic [1:0]           done_cause,
    output logic [ENTRY_W-OFF_W-1:0] done_ppn,
    output logic [ENTRY_W-1:0]   done_paddr,
    output logic                 done_writable,
    output logic                 done_user
);
    import pw_pkg::*;

    localparam int PPN_W = ENTRY_W - OFF_W;

    walk_state_t  state;
    fault_cause_t cause_q;
    logic [VA_W-1:0]    va_q;
    logic [ENTRY_W-1:0] base_q;
    logic [ENTRY_W-1:0] dir_q;
    logic [ENTRY_W-1:0] tbl_q;
    logic               wr_q;
    logic               usr_q;
    logic               effw_q;
    logic               effu_q;
    logic               eff_write;
    logic               eff_user;
    logic               deny;

    pw_addr_gen #(
        .VA_W(VA_W), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_addr (
        .base      (base_q),
        .vaddr     (va_q),
        .dir_entry (dir_q),
        .sel_table (state == ST_FETCH_TBL),
        .addr      (mem_rd_addr)
    );

    pw_perm_check #(.ENTRY_W(ENTRY_W)) u_perm (
        .dir_entry (dir_q),
        .tbl_entry (mem_rsp_data),
        .is_write  (wr_q),
        .is_user   (usr_q),
        .eff_write (eff_write),
        .eff_user  (eff_user),
        .deny      (deny)
    );

    // Walk sequencer: latch the request, capture entries, decide the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cause_q <= CAUSE_NONE;
            va_q    <= '0;
            base_q  <= '0;
            dir_q   <= '0;
            tbl_q   <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            effw_q  <= 1'b0;
            effu_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    base_q <= base_addr;
                    wr_q   <= req_write;
                    usr_q  <= req_user;
                    state  <= ST_FETCH_DIR;
                end
                ST_FETCH_DIR: state <= ST_WAIT_DIR;
                ST_WAIT_DIR: if (mem_rsp_valid) begin
                    dir_q <= mem_rsp_data;
                    if (!mem_rsp_data[FLAG_PRESENT]) begin
                        cause_q <= CAUSE_DIR_ABSENT;
                        state   <= ST_FAULT;
                    end else begin
                        state <= ST_FETCH_TBL;
                    end
                end
                ST_FETCH_TBL: state <= ST_WAIT_TBL;
                ST_WAIT_TBL: if (mem_rsp_valid) begin
                    tbl_q  <= mem_rsp_data;
                    effw_q <= eff_write;
                    effu_q <= eff_user;
                    if (!mem_rsp_data[FLAG_PRESENT]) begin
                        cause_q <= CAUSE_TBL_ABSENT;
                        state   <= ST_FAULT;
                    end else if (deny) begin
                        cause_q <= CAUSE_PROT;
                        state   <= ST_FAULT;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode handshake and result outputs from the state and captured entries.
    always_comb begin
        busy          = (state != ST_IDLE);
        mem_rd_valid  = (state == ST_FETCH_DIR) || (state == ST_FETCH_TBL);
        done_valid    = (state == ST_DONE) || (state == ST_FAULT);
        done_fault    = (state == ST_FAULT);
        done_cause    = (state == ST_FAULT) ? cause_q : CAUSE_NONE;
        done_ppn      = (state == ST_DONE) ? tbl_q[ENTRY_W-1:OFF_W] : '0;
        done_paddr    = (state == ST_DONE) ? {tbl_q[ENTRY_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
        done_writable = (state == ST_DONE) & effw_q;
        done_user     = (state == ST_DONE) & effu_q;
    end

    logic unused_ppn_w;
    assign unused_ppn_w = (PPN_W == 0);
endmodule

// File: rtl/pw_checker.sv
// Module: pw_checker
// Cycle-level protocol properties of page_walker, attached by bind.
// Observes ports only; keeps one register of the accepted request.
module pw_checker #(
    parameter int VA_W    = 32,
    parameter int ENTRY_W = 32,
    parameter int IDX_W   = 10,
    parameter int OFF_W   = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic [VA_W-1:0]            req_vaddr,
    input logic [ENTRY_W-1:0]         base_addr,
    input logic                       busy,
    input logic                       mem_rd_valid,
    input logic [ENTRY_W-1:0]         mem_rd_addr,
    input logic                       done_valid,
    input logic                       done_fault,
    input logic [1:0]                 done_cause,
    input logic [ENTRY_W-OFF_W-1:0]   done_ppn,
    input logic [ENTRY_W-1:0]         done_paddr
);
    logic [OFF_W-1:0] off_q;

    // Remember the page offset of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_q <= '0;
        else if (req_valid && !busy)
            off_q <= req_vaddr[OFF_W-1:0];
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_valid && !done_valid));

    p_dir_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (mem_rd_valid &&
            mem_rd_addr == $past(base_addr) + {$past(req_vaddr[VA_W-1 -: IDX_W]), 2'b00}));

    p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_read_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    p_paddr_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |->
            (done_paddr == {done_ppn, off_q} && done_cause == 2'd0));

    p_fault_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |->
            (done_ppn == '0 && done_paddr == '0 && done_cause != 2'd0));
endmodule

bind page_walker pw_checker #(
    .VA_W(VA_W), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
) u_pw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .base_addr    (base_addr),
    .busy         (busy),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .done_valid   (done_valid),
    .done_fault   (done_fault),
    .done_cause   (done_cause),
    .done_ppn     (done_ppn),
    .done_paddr   (done_paddr)
);

// File: tb/tb_page_walker.sv
`timescale 1ns/100ps
// Directed bench for page_walker with a latency-configurable word memory.
module tb_page_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] base_addr = '0;
    logic        busy;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic        done_fault;
    logic [1:0]  done_cause;
    logic [19:0] done_ppn;
    logic [31:0] done_paddr;
    logic        done_writable;
    logic        done_user;

    always #2 clk = ~clk;

    page_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .base_addr(base_addr),
        .busy(busy), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_fault(done_fault), .done_cause(done_cause),
        .done_ppn(done_ppn), .done_paddr(done_paddr),
        .done_writable(done_writable), .done_user(done_user)
    );

    int tests = 0;
    int fails = 0;

    logic [31:0] mem [0:2047];
    int          lat = 1;
    int          reads = 0;
    logic [31:0] rd_log [0:3];
    bit          pend = 0;
    int          cnt = 0;
    logic [31:0] pend_addr = '0;
    int          done_cnt = 0;
    logic        r_fault;
    logic [1:0]  r_cause;
    logic [19:0] r_ppn;
    logic [31:0] r_paddr;
    logic        r_w;
    logic        r_u;

    // Memory responder and result monitor, both on the falling edge.
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[pend_addr[12:2]];
                pend = 0;
            end else begin
                cnt = cnt - 1;
            end
        end
        if (mem_rd_valid) begin
            if (reads < 4) rd_log[reads] = mem_rd_addr;
            reads = reads + 1;
            pend = 1;
            cnt = lat - 1;
            pend_addr = mem_rd_addr;
        end
        if (done_valid) begin
            done_cnt = done_cnt + 1;
            r_fault = done_fault; r_cause = done_cause; r_ppn = done_ppn;
            r_paddr = done_paddr; r_w = done_writable; r_u = done_user;
        end
    end

    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Run one walk; optionally present stray requests while busy.
    task automatic do_walk(input logic [31:0] base, input logic [31:0] va,
                           input logic wr, input logic us, input int l, input bit stray);
        int d0;
        int w;
        lat = l;
        step();
        base_addr = base; req_vaddr = va; req_write = wr; req_user = us;
        req_valid = 1'b1;
        reads = 0;
        d0 = done_cnt;
        step();
        req_valid = 1'b0;
        if (stray) begin
            for (int i = 0; i < 4; i++) begin
                chk(busy == 1'b1, "R8", "busy during walk", {31'b0, busy}, 32'h1);
                req_valid = 1'b1; req_vaddr = 32'hFFFF_F123; base_addr = 32'h0000_1800;
                step();
            end
            req_valid = 1'b0;
        end
        w = 0;
        while (done_cnt == d0 && w < 60) begin
            step();
            w++;
        end
        repeat (3) step();
        chk(done_cnt == d0 + 1, "R9", "one result pulse", done_cnt - d0, 1);
        chk(busy == 1'b0, "R8", "idle after walk", {31'b0, busy}, 32'h0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1", "busy in reset", {31'b0, busy}, 0);
        chk(mem_rd_valid == 1'b0, "R1", "read in reset", {31'b0, mem_rd_valid}, 0);
        chk(done_valid == 1'b0, "R1", "done in reset", {31'b0, done_valid}, 0);
    endtask

    task automatic t_success();
        do_walk(32'h1000, {10'd3, 10'd7, 12'hABC}, 1'b1, 1'b1, 1, 1'b0);
        chk(reads == 2, "R3", "read count", reads, 2);
        chk(rd_log[0] == 32'h100C, "R2", "directory address", rd_log[0], 32'h100C);
        chk(rd_log[1] == 32'h001C, "R3", "table address", rd_log[1], 32'h001C);
        chk(r_fault == 1'b0 && r_cause == 2'd0, "R7", "no fault", {30'b0, r_cause}, 0);
        chk(r_ppn == 20'h12345, "R7", "ppn", {12'b0, r_ppn}, 32'h12345);
        chk(r_paddr == 32'h12345ABC, "R7", "paddr", r_paddr, 32'h12345ABC);
        chk(r_w && r_u, "R7", "rights", {30'b0, r_w, r_u}, 3);
    endtask

    task automatic t_dir_absent();
        do_walk(32'h1000, {10'd5, 10'd1, 12'h010}, 1'b0, 1'b0, 2, 1'b0);
        chk(reads == 1, "R4", "no table read", reads, 1);
        chk(r_fault && r_cause == 2'd1, "R4", "cause", {30'b0, r_cause}, 1);
        chk(r_ppn == 0 && r_paddr == 0 && !r_w && !r_u, "R10", "fault payload", r_paddr, 0);
    endtask

    task automatic t_tbl_absent();
        do_walk(32'h1000, {10'd3, 10'd8, 12'h004}, 1'b0, 1'b0, 1, 1'b0);
        chk(reads == 2, "R5", "read count", reads, 2);
        chk(r_fault && r_cause == 2'd2, "R5", "cause", {30'b0, r_cause}, 2);
        chk(r_paddr == 0, "R10", "fault paddr", r_paddr, 0);
    endtask

    task automatic t_protection();
        do_walk(32'h1000, {10'd3, 10'd9, 12'h000}, 1'b1, 1'b0, 1, 1'b0);
        chk(r_fault && r_cause == 2'd3, "R6", "write to read-only table entry", {30'b0, r_cause}, 3);
        do_walk(32'h1000, {10'd4, 10'd10, 12'h020}, 1'b1, 1'b0, 1, 1'b0);
        chk(r_fault && r_cause == 2'd3, "R6", "write under read-only directory", {30'b0, r_cause}, 3);
        do_walk(32'h1000, {10'd4, 10'd10, 12'h020}, 1'b0, 1'b1, 1, 1'b0);
        chk(!r_fault && r_paddr == 32'h66666020, "R6", "user read allowed", r_paddr, 32'h66666020);
        chk(!r_w && r_u, "R7", "rights AND", {30'b0, r_w, r_u}, 1);
        do_walk(32'h1000, {10'd6, 10'd11, 12'h0F0}, 1'b0, 1'b1, 1, 1'b0);
        chk(r_fault && r_cause == 2'd3, "R6", "user under supervisor directory", {30'b0, r_cause}, 3);
        do_walk(32'h1000, {10'd6, 10'd11, 12'h0F0}, 1'b1, 1'b0, 1, 1'b0);
        chk(!r_fault && r_w && !r_u, "R6", "supervisor write", {30'b0, r_w, r_u}, 2);
    endtask

    task automatic t_other_base();
        do_walk(32'h1800, {10'd2, 10'd12, 12'h345}, 1'b0, 1'b0, 3, 1'b0);
        chk(rd_log[0] == 32'h1808, "R2", "directory address, new base", rd_log[0], 32'h1808);
        chk(rd_log[1] == 32'h0030, "R3", "table address, slow memory", rd_log[1], 32'h0030);
        chk(!r_fault && r_paddr == 32'h0ABCD345, "R7", "paddr, slow memory", r_paddr, 32'h0ABCD345);
    endtask

    task automatic t_busy_ignore();
        do_walk(32'h1000, {10'd3, 10'd7, 12'h111}, 1'b0, 1'b0, 2, 1'b1);
        chk(reads == 2, "R8", "stray requests add no reads", reads, 2);
        chk(rd_log[0] == 32'h100C, "R8", "first read unchanged", rd_log[0], 32'h100C);
        chk(r_paddr == 32'h12345111, "R8", "result of first request", r_paddr, 32'h12345111);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        mem[(32'h100C) >> 2] = 32'h0000_0007;
        mem[(32'h1014) >> 2] = 32'h0000_0006;
        mem[(32'h1010) >> 2] = 32'h0000_0005;
        mem[(32'h1018) >> 2] = 32'h0000_0003;
        mem[(32'h1808) >> 2] = 32'h0000_0007;
        mem[7]  = 32'h1234_5007;
        mem[8]  = 32'hABCD_E006;
        mem[9]  = 32'h5555_5005;
        mem[10] = 32'h6666_6007;
        mem[11] = 32'h7777_7007;
        mem[12] = 32'h0ABC_D003;
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_success();
        t_dir_absent();
        t_tbl_absent();
        t_protection();
        t_other_base();
        t_busy_ignore();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule